// File: doc/BRIEF.md
# Counted-Loop Branch Unit

This unit executes the loop-closing instruction of a counted loop. In one step it adds a step value to an iteration counter, compares the new counter with a limit using one of four signed comparison kinds, and picks the next instruction address. That address is the loop top (the current instruction address plus a sign-extended word offset) when another iteration will run, and the next sequential instruction when it will not.

The decision is computed exactly from the counter and limit, not guessed. The last iteration is therefore never over-predicted and the loop branch never mispredicts. Every result carries a flag that keeps the shared branch-prediction tables from being trained on it. The updated counter is returned with a write-back enable whether or not the branch is taken.

Operands are presented with a valid strobe. Results appear on the registered outputs at the next clock edge, so the add, compare and branch together take a single cycle.

Top module: `loop_br_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, outValid, outTaken, outCounterWe and outNoTrain are all low.
- R2: A result appears on the outputs exactly one clock edge after inValid is high. outValid follows inValid with that one-cycle delay.
- R3: outCounter equals inCounter plus inStep, taken modulo 2^64. outCounterWe is high for every valid result, whether the branch is taken or not.
- R4: The comparison is between the updated counter and inLimit, as signed 64-bit values. The inKind encoding is 0 = less-than, 1 = less-or-equal, 2 = not-equal and 3 = greater-than. outTaken is high exactly when the selected comparison holds.
- R5: When the branch is taken, outNextIp equals inIp plus the sign-extended 16-bit inOffset multiplied by 4.
- R6: When the branch is not taken, outNextIp equals inIp plus 4.
- R7: outNoTrain is high with every valid result and low whenever outValid is low.
- R8: A zero step whose comparison still holds gives a taken branch on every issue, with the counter unchanged and no other effect.
- R9: A cycle with inValid low leaves outValid, outTaken, outCounterWe and outNoTrain low on the following cycle.
- R10: Negative counters and limits compare by signed value. For example, a counter of -1 is less than a limit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Loop instruction operands present |
| inCounter | input | 64 | Current iteration counter |
| inStep | input | 64 | Value added to the counter |
| inLimit | input | 64 | Loop limit |
| inKind | input | 2 | Comparison kind (0 lt, 1 le, 2 ne, 3 gt) |
| inOffset | input | 16 | Signed word offset to the loop top |
| inIp | input | 64 | Address of the loop instruction |
| outValid | output | 1 | Result valid |
| outCounter | output | 64 | Updated counter |
| outCounterWe | output | 1 | Counter write-back enable |
| outTaken | output | 1 | Branch back to the loop top |
| outNextIp | output | 64 | Next instruction address |
| outNoTrain | output | 1 | Exclude this branch from predictor training |

## Verification
The bench aims at the final-iteration boundary, where the updated counter equals the limit. Here a design that compares the old counter, or that confuses less-than with less-or-equal, loops one time too many or too few. Negative counters and limits expose an unsigned comparison, which would leave a loop early. Backward offsets expose missing sign extension, which would send the branch far forward. An add that wraps past the top of the signed range checks the modular counter. Zero-step cases and untaken branches confirm that the counter is still written back and that the fall-through address is the instruction plus four.

// File: rtl/loop_br_pkg.sv
package loop_br_pkg;
  typedef enum logic [1:0] {
    CMP_LT = 2'd0,
    CMP_LE = 2'd1,
    CMP_NE = 2'd2,
    CMP_GT = 2'd3
  } cmpKind_t;

  typedef struct packed {
    logic load;     // capture a new result
    logic take;     // branch back to loop top
    logic noTrain;  // keep predictor untouched
  } loopStrobe_t;
endpackage

// File: rtl/loop_br_datapath.sv
module loop_br_datapath
  import loop_br_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int OFFSET_W = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  loopStrobe_t         strobe,
  input  logic [XLEN-1:0]     inCounter,
  input  logic [XLEN-1:0]     inStep,
  input  logic [XLEN-1:0]     inLimit,
  input  logic [OFFSET_W-1:0] inOffset,
  input  logic [XLEN-1:0]     inIp,
  output logic                cmpLess,
  output logic                cmpEqual,
  output logic [XLEN-1:0]     outCounter,
  output logic [XLEN-1:0]     outNextIp
);
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);
  localparam int EXT_W = XLEN - OFFSET_W - WORD_SHIFT;

  logic [XLEN-1:0] sumCount;
  logic [XLEN-1:0] byteOffset;
  logic [XLEN-1:0] targetIp;
  logic [XLEN-1:0] fallIp;

  always_comb begin
    sumCount   = inCounter + inStep;
    cmpLess    = $signed(sumCount) < $signed(inLimit);
    cmpEqual   = sumCount == inLimit;
    byteOffset = {{EXT_W{inOffset[OFFSET_W-1]}}, inOffset, {WORD_SHIFT{1'b0}}};
    targetIp   = inIp + byteOffset;
    fallIp     = inIp + XLEN'(WORD_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outCounter <= '0;
      outNextIp  <= '0;
    end else if (strobe.load) begin
      outCounter <= sumCount;
      outNextIp  <= strobe.take ? targetIp : fallIp;
    end
  end

  // R3: counter result is the modular sum of the operands from the previous cycle
  assert_counter_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.load) && $past(rst_n) |-> outCounter == $past(inCounter + inStep));

  // R6: fall-through address follows the loop instruction
  assert_fall_ip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.load) && !$past(strobe.take) && $past(rst_n)
      |-> outNextIp == $past(inIp) + XLEN'(WORD_BYTES));
endmodule

// File: rtl/loop_br_control.sv
module loop_br_control
  import loop_br_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [1:0]  inKind,
  input  logic        cmpLess,
  input  logic        cmpEqual,
  output loopStrobe_t strobe,
  output logic        outValid,
  output logic        outTaken,
  output logic        outCounterWe,
  output logic        outNoTrain
);
  cmpKind_t kind;
  logic     holds;

  always_comb begin
    kind = cmpKind_t'(inKind);
    unique case (kind)
      CMP_LT:  holds = cmpLess;
      CMP_LE:  holds = cmpLess | cmpEqual;
      CMP_NE:  holds = !cmpEqual;
      CMP_GT:  holds = !cmpLess && !cmpEqual;
      default: holds = 1'b0;
    endcase
    strobe.load    = inValid;
    strobe.take    = inValid && holds;
    strobe.noTrain = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      outTaken     <= 1'b0;
      outCounterWe <= 1'b0;
      outNoTrain   <= 1'b0;
    end else begin
      outValid     <= strobe.load;
      outTaken     <= strobe.take;
      outCounterWe <= strobe.load;
      outNoTrain   <= strobe.noTrain;
    end
  end

  // R2: one-cycle latency from operands to result
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> outValid == $past(inValid));

  // R7: predictor exclusion accompanies exactly the valid results
  assert_no_train_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outNoTrain == outValid);

  // R3: counter write-back on every valid result, taken or not
  assert_counter_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outCounterWe == outValid);

  // R9: no taken branch without a valid result
  assert_taken_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outTaken |-> outValid);
endmodule

// File: rtl/loop_br_unit.sv
module loop_br_unit
  import loop_br_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int OFFSET_W = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [XLEN-1:0]     inCounter,
  input  logic [XLEN-1:0]     inStep,
  input  logic [XLEN-1:0]     inLimit,
  input  logic [1:0]          inKind,
  input  logic [OFFSET_W-1:0] inOffset,
  input  logic [XLEN-1:0]     inIp,
  output logic                outValid,
  output logic [XLEN-1:0]     outCounter,
  output logic                outCounterWe,
  output logic                outTaken,
  output logic [XLEN-1:0]     outNextIp,
  output logic                outNoTrain
);
  loopStrobe_t strobe;
  logic        cmpLess;
  logic        cmpEqual;

  loop_br_control u_control (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inKind(inKind),
    .cmpLess(cmpLess), .cmpEqual(cmpEqual), .strobe(strobe),
    .outValid(outValid), .outTaken(outTaken),
    .outCounterWe(outCounterWe), .outNoTrain(outNoTrain)
  );

  loop_br_datapath #(.XLEN(XLEN), .OFFSET_W(OFFSET_W), .WORD_BYTES(WORD_BYTES)) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .inCounter(inCounter), .inStep(inStep), .inLimit(inLimit),
    .inOffset(inOffset), .inIp(inIp),
    .cmpLess(cmpLess), .cmpEqual(cmpEqual),
    .outCounter(outCounter), .outNextIp(outNextIp)
  );
endmodule

// File: tb/loop_br_unit_bench.sv
module loop_br_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inCounter = '0, inStep = '0, inLimit = '0, inIp = '0;
  logic [1:0]  inKind = '0;
  logic [15:0] inOffset = '0;
  logic        outValid, outCounterWe, outTaken, outNoTrain;
  logic [63:0] outCounter, outNextIp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_br_unit u_loop_br_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inCounter(inCounter),
    .inStep(inStep), .inLimit(inLimit), .inKind(inKind), .inOffset(inOffset),
    .inIp(inIp), .outValid(outValid), .outCounter(outCounter),
    .outCounterWe(outCounterWe), .outTaken(outTaken), .outNextIp(outNextIp),
    .outNoTrain(outNoTrain)
  );

  function automatic bit expTake(logic [63:0] c, logic [63:0] s, logic [63:0] l, logic [1:0] k);
    longint n = longint'(c + s);
    longint lim = longint'(l);
    case (k)
      2'd0: return n < lim;
      2'd1: return n <= lim;
      2'd2: return n != lim;
      default: return n > lim;
    endcase
  endfunction

  function automatic logic [63:0] expTarget(logic [63:0] ip, logic [15:0] off);
    logic [63:0] ext = {{48{off[15]}}, off};
    return ip + (ext << 2);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic issue(string req, logic [63:0] c, logic [63:0] s, logic [63:0] l,
                       logic [1:0] k, logic [15:0] off, logic [63:0] ip);
    bit t;
    inValid = 1'b1; inCounter = c; inStep = s; inLimit = l;
    inKind = k; inOffset = off; inIp = ip;
    t = expTake(c, s, l, k);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R2 valid"}, 64'(outValid), 64'd1);
    check({req, " R3 counter"}, outCounter, c + s);
    check({req, " R3 we"}, 64'(outCounterWe), 64'd1);
    check({req, " R4 taken"}, 64'(outTaken), 64'(t));
    if (t) check({req, " R5 target"}, outNextIp, expTarget(ip, off));
    else   check({req, " R6 fall"}, outNextIp, ip + 64'd4);
    check({req, " R7 notrain"}, 64'(outNoTrain), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(outValid), 64'd0);
    check("R1 taken", 64'(outTaken), 64'd0);
    check("R1 we", 64'(outCounterWe), 64'd0);
    check("R1 notrain", 64'(outNoTrain), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post valid", 64'(outValid), 64'd0);
    check("R9 idle notrain", 64'(outNoTrain), 64'd0);

    // final-iteration boundary: new counter equals limit
    issue("R4 lt boundary", 64'd9, 64'd1, 64'd10, 2'd0, 16'hFFF0, 64'h1000);
    issue("R4 le boundary", 64'd9, 64'd1, 64'd10, 2'd1, 16'hFFF0, 64'h1000);
    issue("R4 ne boundary", 64'd9, 64'd1, 64'd10, 2'd2, 16'hFFF0, 64'h1000);
    issue("R4 gt down", 64'd5, -64'sd1, 64'd3, 2'd3, 16'hFFFC, 64'h2000);
    issue("R4 gt exit", 64'd4, -64'sd1, 64'd3, 2'd3, 16'hFFFC, 64'h2000);
    // signed comparisons
    issue("R10 neg lt", -64'sd2, 64'd1, 64'd0, 2'd0, 16'hFF00, 64'h3000);
    issue("R10 neg gt", 64'd0, 64'd1, -64'sd5, 2'd3, 16'h0010, 64'h3000);
    // wrap past signed max
    issue("R3 wrap", 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 2'd0, 16'h8000, 64'h4000);
    // zero step, condition holds: loops forever
    issue("R8 zero step", 64'd7, 64'd0, 64'd100, 2'd0, 16'hFFF8, 64'h5000);
    issue("R8 zero step again", 64'd7, 64'd0, 64'd100, 2'd0, 16'hFFF8, 64'h5000);
    // forward offset
    issue("R5 forward", 64'd0, 64'd2, 64'd100, 2'd2, 16'h7FFF, 64'h6000);

    @(negedge clk);
    check("R9 idle valid", 64'(outValid), 64'd0);
    check("R9 idle taken", 64'(outTaken), 64'd0);
    check("R9 idle we", 64'(outCounterWe), 64'd0);
    check("R7 idle notrain", 64'(outNoTrain), 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] c, s, l;
      c = {32'($urandom), 32'($urandom)};
      s = 64'($signed(8'($urandom)));
      l = ($urandom % 2) ? c + s : c + s + 64'($signed(4'($urandom)));
      issue("R4 random", c, s, l, 2'($urandom), 16'($urandom), {32'd0, $urandom} & ~64'd3);
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        check("R9 gap valid", 64'(outValid), 64'd0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule